// File: doc/BRIEF.md
# Variable-Length Bus Cycle Phase Sequencer

This block paces a processor's bus cycles inside a single-clock design. It runs on a work clock at half the reference master clock. It produces no derived clocks. Instead it keeps a phase counter and emits one-cycle clock-enable strobes. Each bus cycle lasts 3, 4 or 6 work-clock phases. The length depends on an access type that the processor core presents at the start of the cycle: internal (no bus access), memory, I/O, or a DMA transfer cycle.

Three strobes come out of the block:
- A compute strobe in phase 0 of every cycle, on which the core advances.
- A mid-cycle strobe. A read strobe accompanies it when the cycle carries a read, so the data is ready for the following cycle.
- A write strobe. A write belonging to one cycle is issued in phase 0 of the next cycle, overlapping that cycle's compute step.

A hold input freezes the sequencer, for example for frame synchronisation. All pins are plain control signals. There is no data stream, so no valid/ready handshake applies.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset the counter is at phase 0 of an internal-type cycle, and no write is pending (write strobe low in the first phase 0).
- R2: An internal cycle (access type 0) lasts 3 phases.
- R3: A memory cycle (access type 1) lasts 4 phases.
- R4: An I/O cycle (access type 2) lasts 6 phases.
- R5: A DMA cycle (access type 3) lasts 4 phases.
- R6: The compute strobe is high in phase 0 of every cycle and in no other phase.
- R7: The mid-cycle strobe is high only in phase length/2 (phase 1, 2 or 3 for lengths 3, 4, 6). The read strobe is high together with it exactly when the cycle carries a read.
- R8: A write requested for a cycle produces the write strobe in phase 0 of the next cycle, together with that cycle's compute strobe, and in no other phase.
- R9: Access type, read request and write request are sampled only in phase 0. Changes to them in other phases have no effect on the running cycle.
- R10: While hold is high the phase stays fixed and no strobe is emitted. A write pending at phase 0 is kept and issued once hold drops.
- R11: A memory or I/O cycle requesting both read and write performs only the read. A DMA cycle carries both.
- R12: An internal cycle ignores read and write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Work clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Freeze sequencer; suppress strobes |
| acc_type_i | input | 2 | Access type: 0 internal, 1 memory, 2 I/O, 3 DMA |
| rd_req_i | input | 1 | Cycle carries a read (sampled in phase 0) |
| wr_req_i | input | 1 | Cycle carries a write (sampled in phase 0) |
| phase_o | output | PHASE_W (3) | Current phase within the cycle |
| comp_stb_o | output | 1 | Compute enable, phase 0 |
| mid_stb_o | output | 1 | Mid-cycle enable |
| rd_stb_o | output | 1 | Read issue enable |
| wr_stb_o | output | 1 | Deferred write issue enable |

## Verification
The deferred write of one cycle and the compute step of the next cycle fall in the same phase. The bench runs write-carrying cycles of every type back to back. In the following phase 0 it expects the write strobe and the compute strobe high together, and in all other phases it expects both low. The same coincidence is tested across a hold taken at phase 0. There the two strobes must both stay low for the whole hold and then rise together in the first free phase, with the access type sampled only at that point.

// File: rtl/bus_phase_pkg.sv
package bus_phase_pkg;
  typedef enum logic [1:0] {
    ACC_INT = 2'd0,
    ACC_MEM = 2'd1,
    ACC_IO  = 2'd2,
    ACC_DMA = 2'd3
  } acc_e;
endpackage

// File: rtl/bus_len_decode.sv
module bus_len_decode
  import bus_phase_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int LEN_INT = 3,
  parameter int LEN_MEM = 4,
  parameter int LEN_IO  = 6,
  parameter int LEN_DMA = 4
) (
  input  acc_e               typ_i,
  output logic [PHASE_W-1:0] last_o,
  output logic [PHASE_W-1:0] mid_o
);
  int len;

  always_comb begin
    case (typ_i)
      ACC_MEM: len = LEN_MEM;
      ACC_IO:  len = LEN_IO;
      ACC_DMA: len = LEN_DMA;
      default: len = LEN_INT;
    endcase
    last_o = PHASE_W'(len - 1);
    mid_o  = PHASE_W'(len / 2);
  end
endmodule

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr
  import bus_phase_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int LEN_INT = 3,
  parameter int LEN_IO  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  acc_e               typ_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [PHASE_W-1:0] last_i,
  input  logic [PHASE_W-1:0] mid_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] mid_o,
  output acc_e               typ_o,
  output logic               rd_o,
  output logic               wr_pend_o
);
  logic [PHASE_W-1:0] phase_q, last_q, mid_q;
  acc_e typ_q;
  logic rd_q, wr_q;
  logic start, rd_take, wr_take;

  assign start   = (phase_q == '0) && !hold_i;
  assign rd_take = rd_i && (typ_i != ACC_INT);
  assign wr_take = wr_i && ((typ_i == ACC_DMA) || ((typ_i != ACC_INT) && !rd_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      last_q  <= PHASE_W'(LEN_INT - 1);
      mid_q   <= PHASE_W'(LEN_INT / 2);
      typ_q   <= ACC_INT;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (!hold_i) begin
      if (start) begin
        last_q  <= last_i;
        mid_q   <= mid_i;
        typ_q   <= typ_i;
        rd_q    <= rd_take;
        wr_q    <= wr_take;
        phase_q <= phase_q + 1'b1;
      end else if (phase_q == last_q) begin
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_o   = phase_q;
  assign mid_o     = mid_q;
  assign typ_o     = typ_q;
  assign rd_o      = rd_q;
  assign wr_pend_o = wr_q;

  // R10: phase frozen under hold
  a_r10_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(phase_q));
  // R6: a running cycle either steps or wraps to phase 0
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && phase_q != '0) |=> (phase_q == '0 || phase_q == $past(phase_q) + 1'b1));
  // R4: no cycle is longer than the I/O cycle
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_q) < LEN_IO);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PHASE_W-1:0] mid_i,
  input  logic               rd_i,
  input  logic               wr_pend_i,
  output logic               comp_stb_o,
  output logic               mid_stb_o,
  output logic               rd_stb_o,
  output logic               wr_stb_o
);
  logic go;
  assign go         = !hold_i;
  assign comp_stb_o = go && (phase_i == '0);
  assign mid_stb_o  = go && (phase_i == mid_i);
  assign rd_stb_o   = mid_stb_o && rd_i;
  assign wr_stb_o   = comp_stb_o && wr_pend_i;

  // R10: silence under hold
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !(comp_stb_o || mid_stb_o || rd_stb_o || wr_stb_o));
  // R6: compute strobe never in two consecutive phases
  a_r6_single_comp: assert property (@(posedge clk) disable iff (!rst_n)
    comp_stb_o |=> !comp_stb_o);
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bus_phase_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int LEN_INT = 3,
  parameter int LEN_MEM = 4,
  parameter int LEN_IO  = 6,
  parameter int LEN_DMA = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic [1:0]         acc_type_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               comp_stb_o,
  output logic               mid_stb_o,
  output logic               rd_stb_o,
  output logic               wr_stb_o
);
  acc_e typ_in, typ_cur;
  logic [PHASE_W-1:0] dec_last, dec_mid, cur_mid, phase;
  logic rd_cur, wr_pend;

  assign typ_in = acc_e'(acc_type_i);

  bus_len_decode #(
    .PHASE_W(PHASE_W), .LEN_INT(LEN_INT), .LEN_MEM(LEN_MEM),
    .LEN_IO(LEN_IO), .LEN_DMA(LEN_DMA)
  ) u_dec (
    .typ_i(typ_in), .last_o(dec_last), .mid_o(dec_mid)
  );

  bus_phase_ctr #(
    .PHASE_W(PHASE_W), .LEN_INT(LEN_INT), .LEN_IO(LEN_IO)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .typ_i(typ_in),
    .rd_i(rd_req_i), .wr_i(wr_req_i), .last_i(dec_last), .mid_i(dec_mid),
    .phase_o(phase), .mid_o(cur_mid), .typ_o(typ_cur),
    .rd_o(rd_cur), .wr_pend_o(wr_pend)
  );

  bus_strobe_gen #(.PHASE_W(PHASE_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .phase_i(phase),
    .mid_i(cur_mid), .rd_i(rd_cur), .wr_pend_i(wr_pend),
    .comp_stb_o(comp_stb_o), .mid_stb_o(mid_stb_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o)
  );

  assign phase_o = phase;

  // R12: internal cycles never read
  a_r12_int_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> (typ_cur != ACC_INT));
  // R8: deferred write only alongside a compute step
  a_r8_wr_with_comp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> comp_stb_o);
  // R7: read only on the mid-cycle strobe
  a_r7_rd_on_mid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |-> mid_stb_o);
endmodule

// File: tb/bus_phase_seq_tb.sv
`timescale 1ns/1ps
module bus_phase_seq_tb;
  logic clk = 1'b0;
  logic rst_n, hold;
  logic [1:0] acc;
  logic rd, wr;
  logic [2:0] phase;
  logic comp_stb, mid_stb, rd_stb, wr_stb;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit exp_pend = 1'b0;
  string pend_tag = "R1";

  always #2.5 clk = ~clk;

  bus_phase_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .acc_type_i(acc),
    .rd_req_i(rd), .wr_req_i(wr), .phase_o(phase), .comp_stb_o(comp_stb),
    .mid_stb_o(mid_stb), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb)
  );

  // {type, rd, wr}
  localparam logic [3:0] VEC [12] = '{
    {2'd0,1'b0,1'b0}, {2'd1,1'b1,1'b0}, {2'd1,1'b0,1'b1}, {2'd2,1'b1,1'b0},
    {2'd2,1'b0,1'b1}, {2'd3,1'b1,1'b1}, {2'd0,1'b1,1'b1}, {2'd1,1'b1,1'b1},
    {2'd2,1'b1,1'b1}, {2'd3,1'b0,1'b1}, {2'd3,1'b1,1'b0}, {2'd0,1'b0,1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Run one full cycle starting in phase 0; scramble inputs after phase 0 (R9)
  task automatic run_cyc(input logic [1:0] t, input logic r, input logic w);
    int elen, emid, n;
    bit erd, ewr;
    string ltag;
    acc = t; rd = r; wr = w; #0.1;
    case (t)
      2'd0: begin elen = 3; ltag = "R2"; end
      2'd1: begin elen = 4; ltag = "R3"; end
      2'd2: begin elen = 6; ltag = "R4"; end
      default: begin elen = 4; ltag = "R5"; end
    endcase
    emid = elen / 2;
    erd  = r && (t != 2'd0);
    ewr  = w && ((t == 2'd3) || ((t != 2'd0) && !r));
    chk(phase == 3'd0 && comp_stb, "R6 compute at phase 0", int'(comp_stb), 1);
    chk(wr_stb == exp_pend, pend_tag, int'(wr_stb), int'(exp_pend));
    step();
    acc = ~t; rd = ~r; wr = ~w;
    n = 1;
    while (phase != 3'd0 && n < 10) begin
      chk(!comp_stb && !wr_stb, "R6 R8 quiet off phase 0", int'(comp_stb | wr_stb), 0);
      if (n == emid) begin
        chk(mid_stb, "R7 mid strobe", int'(mid_stb), 1);
        chk(rd_stb == erd, (t == 2'd0) ? "R12 read ignored" :
            (r && w && t != 2'd3) ? "R11 read kept" : "R7 read strobe",
            int'(rd_stb), int'(erd));
      end else begin
        chk(!mid_stb && !rd_stb, "R7 strobes off mid", int'(mid_stb | rd_stb), 0);
      end
      step();
      n++;
    end
    chk(n == elen, {ltag, " cycle length, R9 sampling"}, n, elen);
    exp_pend = ewr;
    pend_tag = (t == 2'd0) ? "R12 write ignored" :
               (r && w) ? "R11 write handling" : "R8 deferred write";
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; acc = 2'd2; rd = 1'b1; wr = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    acc = 2'd0; rd = 1'b0; wr = 1'b0; #0.1;
    // R1 reset state
    chk(phase == 3'd0, "R1 reset phase", int'(phase), 0);
    chk(!wr_stb, "R1 no pending write", int'(wr_stb), 0);

    for (int i = 0; i < 12; i++) run_cyc(VEC[i][3:2], VEC[i][1], VEC[i][0]);

    // R10 hold mid-cycle in an I/O read cycle
    acc = 2'd2; rd = 1'b1; wr = 1'b0;
    step();
    hold = 1'b1; #0.1;
    repeat (3) begin
      chk(phase == 3'd1, "R10 phase held", int'(phase), 1);
      chk(!(comp_stb | mid_stb | rd_stb | wr_stb), "R10 strobes off", 1, 0);
      step();
    end
    hold = 1'b0;
    step();
    chk(phase == 3'd2, "R10 resume phase", int'(phase), 2);
    step();
    chk(phase == 3'd3 && mid_stb && rd_stb, "R7 I/O read at phase 3", int'(phase), 3);
    repeat (3) step();
    chk(phase == 3'd0, "R4 I/O length across hold", int'(phase), 0);
    exp_pend = 1'b0; pend_tag = "R8 no write";

    // R10 hold at phase 0 with a pending write, type changed during hold
    run_cyc(2'd1, 1'b0, 1'b1);
    hold = 1'b1; acc = 2'd2; #0.1;
    repeat (2) begin
      chk(phase == 3'd0 && !comp_stb && !wr_stb, "R10 hold at phase 0", int'(wr_stb), 0);
      step();
    end
    hold = 1'b0;
    run_cyc(2'd0, 1'b0, 1'b0);
    pend_tag = "R8 no write after release";
    run_cyc(2'd3, 1'b1, 1'b1);
    run_cyc(2'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule